// File: doc/BRIEF.md
# DMA Channel Interrupt Register File

This block holds the interrupt state of one DMA channel. It has eight sticky event flags, an interrupt mask, a three-bit completion counter and one level interrupt line. The channel datapath raises single-cycle event pulses. Software sees the state through full-word register accesses. Each flag stays set until software writes a one to its position in the flag register.

Software never writes the mask directly. A write to the unmask alias clears the selected mask bits, and a write to the mask-set alias sets them. Both aliases read as zero, and the mask itself is read-only. Each completion event adds one to the counter in the status word. Clearing a set completion flag takes one away. The interrupt line is high while any flag is set whose mask bit is clear.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset the flag register reads 0x00, the mask reads 0xFF, the status word reads 0 and the interrupt output is low.
- R2: An event pulse on evtSet bit i sets flag bit i, and the bit stays set with no further pulse. Flag positions are: 7 overflow, 6 bad access, 5 threshold, 4 memory timeout, 3 stream timeout, 2 bus error, 1 done, 0 memory done.
- R3: A full write to offset 0x14 clears each flag bit whose data bit is 1 and leaves the other flag bits unchanged.
- R4: When an event pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R5: A full write to offset 0x18 clears the mask bits selected by data bits [7:0]. Offset 0x18 reads as zero.
- R6: A full write to offset 0x1C sets the mask bits selected by data bits [7:0]. Offset 0x1C reads as zero.
- R7: The mask at offset 0x20 is read-only, and a write to 0x20 leaves it unchanged.
- R8: irqOut is high exactly when some flag bit is set whose mask bit is clear. It follows register changes in the same cycle.
- R9: The completion counter reads at status offset 0x08, bits [15:13]. Each pulse on event bit 1 increments it, and it wraps modulo 8.
- R10: A clearing write with data bit 1 set, while flag bit 1 is set, decrements the counter. An increment and a decrement in the same cycle leave it unchanged. The same write while flag bit 1 is clear leaves the counter unchanged.
- R11: An access with byte enables other than 4'hF, or with address bits [1:0] non-zero, changes no state, and as a read it returns 0.
- R12: A read of an unmapped offset, such as 0x0C, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the access |
| byteEn | input | 4 | Byte enables, must be 4'hF for a valid access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, 0 when rdEn is low |
| evtSet | input | 8 | Single-cycle event pulses from the datapath |
| irqOut | output | 1 | Level interrupt |

## Verification
A wrong flag or mask bit shows up on irqOut in the very next cycle, provided the matching mask bit is open. It also shows up in the readback at 0x14 or 0x20. A counter error can stay hidden until the status word is read, so the bench reads it after every counting step. The bench also runs a reference model that is compared with irqOut and every read on each clock. The same-cycle collision cases are driven on purpose, because their errors leave no trace in the flags that a sequential test would see.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int SRC_N    = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int CNT_W    = 3;
  localparam int CNT_LSB  = 13;
  localparam int DONE_BIT = 1;

  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_UNMK = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_SETM = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h20;

  typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_FLAG, SEL_MASK} rdSelT;

  typedef struct packed {
    logic  clrFlag;
    logic  unmask;
    logic  setMask;
    rdSelT rdSel;
  } strobeT;
endpackage

// File: rtl/irq_regs_ctrl.sv
module irq_regs_ctrl
  import irq_regs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    byteEn,
  output strobeT        strb
);
  logic accessOk;

  // Only whole, word-aligned accesses are decoded.
  assign accessOk = (byteEn == 4'hF) && (addr[1:0] == 2'b00);

  always_comb begin
    strb         = '0;
    strb.rdSel   = SEL_NONE;
    if (accessOk && wrEn) begin
      strb.clrFlag = (addr == OFS_FLAG);
      strb.unmask  = (addr == OFS_UNMK);
      strb.setMask = (addr == OFS_SETM);
    end
    if (accessOk && rdEn) begin
      unique case (addr)
        OFS_STAT: strb.rdSel = SEL_STAT;
        OFS_FLAG: strb.rdSel = SEL_FLAG;
        OFS_MASK: strb.rdSel = SEL_MASK;
        default:  strb.rdSel = SEL_NONE;
      endcase
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrFlag, strb.unmask, strb.setMask})); // R11
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn != 4'hF) |-> (strb == '0)); // R11
endmodule

// File: rtl/irq_regs_dpath.sv
module irq_regs_dpath
  import irq_regs_pkg::*;
#(
  parameter int NS  = SRC_N,
  parameter int DW  = DATA_W,
  parameter int CW  = CNT_W,
  parameter int CL  = CNT_LSB,
  parameter int DB  = DONE_BIT
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic [DW-1:0] wrData,
  input  logic [NS-1:0] evtSet,
  output logic [DW-1:0] rdData,
  output logic          irqOut
);
  logic [NS-1:0] flags, mask, clrBits;
  logic [CW-1:0] doneCnt;
  logic          cntInc, cntDec;

  assign clrBits = strb.clrFlag ? wrData[NS-1:0] : '0;
  assign cntInc  = evtSet[DB];
  assign cntDec  = clrBits[DB] && flags[DB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      mask    <= '1;
      doneCnt <= '0;
    end else begin
      flags   <= (flags & ~clrBits) | evtSet;
      doneCnt <= doneCnt + CW'(cntInc) - CW'(cntDec);
      if (strb.unmask)       mask <= mask & ~wrData[NS-1:0];
      else if (strb.setMask) mask <= mask | wrData[NS-1:0];
    end
  end

  assign irqOut = |(flags & ~mask);

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      SEL_STAT: rdData[CL +: CW] = doneCnt;
      SEL_FLAG: rdData[NS-1:0]   = flags;
      SEL_MASK: rdData[NS-1:0]   = mask;
      default:  rdData = '0;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrFlag |=> ((flags & $past(flags)) == $past(flags))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((flags & $past(evtSet)) == $past(evtSet))); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.unmask || strb.setMask) |=> $stable(mask)); // R7
  AST_CNT_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (cntInc == cntDec) |=> $stable(doneCnt)); // R10
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import irq_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        byteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [SRC_N-1:0]  evtSet,
  output logic              irqOut
);
  strobeT strb;

  irq_regs_ctrl #(.AW(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .byteEn(byteEn), .strb(strb)
  );

  irq_regs_dpath #(
    .NS(SRC_N), .DW(DATA_W), .CW(CNT_W), .CL(CNT_LSB), .DB(DONE_BIT)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .evtSet(evtSet), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_dma_irq_regs.sv
`timescale 1ns/1ps
module tb_dma_irq_regs;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0, rdEn = 0;
  logic [5:0]  addr = '0;
  logic [3:0]  byteEn = 4'hF;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  evtSet = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int mFlags = 0, mMask = 255, mCnt = 0;

  always #10 clk = ~clk;

  dma_irq_regs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .evtSet(evtSet), .irqOut(irqOut)
  );

  function automatic bit okAcc(input logic [5:0] a, input logic [3:0] be);
    return (be == 4'hF) && (a[1:0] == 2'b00);
  endfunction

  function automatic int modelRead(input logic [5:0] a, input logic [3:0] be, input logic rd);
    if (!rd || !okAcc(a, be)) return 0;
    case (a)
      6'h08: return mCnt << 13;
      6'h14: return mFlags;
      6'h20: return mMask;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      int clr, wd;
      wd  = int'(wrData[7:0]);
      clr = (wrEn && okAcc(addr, byteEn) && addr == 6'h14) ? wd : 0;
      mCnt   <= (mCnt + int'(evtSet[1]) - (((clr & mFlags & 2) != 0) ? 1 : 0)) & 7;
      mFlags <= (mFlags & ~clr) | int'(evtSet);
      if (wrEn && okAcc(addr, byteEn) && addr == 6'h18) mMask <= mMask & ~wd;
      if (wrEn && okAcc(addr, byteEn) && addr == 6'h1C) mMask <= (mMask | wd) & 255;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (irqOut !== ((mFlags & ~mMask & 255) != 0)) begin
        errors++;
        $display("FAIL R8 model irq: actual %0b expected %0b", irqOut, (mFlags & ~mMask & 255) != 0);
      end
      checks++;
      if (rdData !== 32'(modelRead(addr, byteEn, rdEn))) begin
        errors++;
        $display("FAIL R3 model read @%h: actual %h expected %h", addr, rdData, modelRead(addr, byteEn, rdEn));
      end
    end
  end

  task automatic busOp(input logic w, input logic [5:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic [7:0] e);
    @(posedge clk); #1;
    wrEn = w; rdEn = 0; addr = a; byteEn = be; wrData = d; evtSet = e;
    @(posedge clk); #1;
    wrEn = 0; addr = '0; byteEn = 4'hF; wrData = '0; evtSet = '0;
  endtask

  task automatic chkRd(input logic [5:0] a, input logic [3:0] be,
                       input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    rdEn = 1; addr = a; byteEn = be;
    @(negedge clk);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s read @%h: actual %h expected %h", tag, a, rdData, exp);
    end
    @(posedge clk); #1;
    rdEn = 0; addr = '0; byteEn = 4'hF;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irqOut, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset values
    chkRd(6'h14, 4'hF, 32'h0, "R1");
    chkRd(6'h20, 4'hF, 32'hFF, "R1");
    chkRd(6'h08, 4'hF, 32'h0, "R1");
    chkIrq(1'b0, "R1");
    // R2 sticky flags, masked so no irq
    busOp(0, 6'h00, 4'hF, 0, 8'h84);
    chkRd(6'h14, 4'hF, 32'h84, "R2");
    chkIrq(1'b0, "R8");
    // R5 unmask bit 2
    busOp(1, 6'h18, 4'hF, 32'h04, 8'h00);
    chkRd(6'h20, 4'hF, 32'hFB, "R5");
    chkIrq(1'b1, "R8");
    chkRd(6'h18, 4'hF, 32'h0, "R5");
    // R6 mask it again
    busOp(1, 6'h1C, 4'hF, 32'h04, 8'h00);
    chkRd(6'h20, 4'hF, 32'hFF, "R6");
    chkIrq(1'b0, "R6");
    chkRd(6'h1C, 4'hF, 32'h0, "R6");
    // R7 direct mask write ignored
    busOp(1, 6'h20, 4'hF, 32'h00, 8'h00);
    chkRd(6'h20, 4'hF, 32'hFF, "R7");
    // R3 clear bit 7 only
    busOp(1, 6'h14, 4'hF, 32'h80, 8'h00);
    chkRd(6'h14, 4'hF, 32'h04, "R3");
    // R9 three completions
    for (int i = 0; i < 3; i++) busOp(0, 6'h00, 4'hF, 0, 8'h02);
    chkRd(6'h08, 4'hF, 32'h6000, "R9");
    chkRd(6'h14, 4'hF, 32'h06, "R9");
    // R10 decrement on clear of set flag
    busOp(1, 6'h14, 4'hF, 32'h02, 8'h00);
    chkRd(6'h08, 4'hF, 32'h4000, "R10");
    chkRd(6'h14, 4'hF, 32'h04, "R3");
    busOp(1, 6'h14, 4'hF, 32'h02, 8'h00);
    chkRd(6'h08, 4'hF, 32'h4000, "R10");
    // R4 / R10 same-cycle set and clear
    busOp(0, 6'h00, 4'hF, 0, 8'h02);
    busOp(1, 6'h14, 4'hF, 32'h02, 8'h02);
    chkRd(6'h14, 4'hF, 32'h06, "R4");
    chkRd(6'h08, 4'hF, 32'h6000, "R10");
    // R9 wrap 3 + 5 = 0
    for (int i = 0; i < 5; i++) busOp(0, 6'h00, 4'hF, 0, 8'h02);
    chkRd(6'h08, 4'hF, 32'h0, "R9");
    // R11 partial and misaligned accesses
    busOp(1, 6'h14, 4'h3, 32'hFF, 8'h00);
    chkRd(6'h14, 4'hF, 32'h06, "R11");
    busOp(1, 6'h19, 4'hF, 32'hFF, 8'h00);
    chkRd(6'h20, 4'hF, 32'hFF, "R11");
    chkRd(6'h14, 4'h3, 32'h0, "R11");
    chkRd(6'h15, 4'hF, 32'h0, "R11");
    // R12 unmapped
    chkRd(6'h0C, 4'hF, 32'h0, "R12");
    // R8 open everything, then clear all
    busOp(1, 6'h18, 4'hF, 32'hFF, 8'h00);
    chkIrq(1'b1, "R8");
    busOp(1, 6'h14, 4'hF, 32'hFF, 8'h00);
    chkIrq(1'b0, "R8");
    chkRd(6'h14, 4'hF, 32'h0, "R3");
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule